// File: doc/BRIEF.md
# Three-Class Request Arbiter with Handler Address Selection

This block decides which of three requesters may take over a processor: a bus-master request from a DMA controller, a non-maskable interrupt line, or a maskable interrupt line. The core's control sequencer supplies two strobes. One marks the end of a machine cycle and the other marks the end of an instruction. The core also supplies its interrupt-enable flag. The arbiter returns exactly one grant. That grant goes either to the DMA controller, which may take the bus at any machine-cycle end, or to the interrupt entry logic, which may only start at an instruction end.

With an interrupt grant, the arbiter reports the source and a target address. For the non-maskable line the target is a fixed handler address. For the maskable line, a two-bit mode selects the target. The target can be an address given by the peripheral, a fixed handler address, or the address of an entry in a vector table. In vectored mode each table entry is two bytes, stored low byte first. The table base is programmable, and the peripheral indexes the table with a type number.

The grant, the source and the target stay frozen until the core acknowledges the interrupt entry.

Top module: `irq_arbiter`

## Requirements
- R1: `dma_grant` and `irq_grant` are never high in the same cycle, and both are low after reset.
- R2: When `dma_req` and `cycle_end` are both sampled high in a cycle with no grant outstanding, `dma_grant` rises on the next cycle whatever the value of `instr_end`. DMA wins over any interrupt request sampled in that same cycle. `dma_req` without `cycle_end` is not granted.
- R3: `dma_grant` stays high while `dma_req` stays high, and falls one cycle after `dma_req` is sampled low. A pending interrupt is granted only on an `instr_end` sampled after the release.
- R4: A rising edge on `nmi_pin` is latched, even if the pin is high for a single cycle. The latched request is granted at the next `instr_end` regardless of `ie_flag`. Without `instr_end` it is not granted.
- R5: A high `int_req` is granted only at an `instr_end` where `ie_flag` is 1. While `ie_flag` is 0 the request stays pending, and it is granted at a later boundary once the flag is 1.
- R6: When a latched NMI and `int_req` are both pending at one instruction end, the NMI is granted (`irq_nmi`=1).
- R7: `irq_grant`, `irq_nmi`, `tgt_addr` and `tgt_is_table` hold their values until `ack` is sampled high. `irq_grant` falls on the next cycle. Acknowledging an NMI clears its latch.
- R8: An NMI grant gives `irq_nmi`=1, `tgt_addr`=`NMI_ADDR`, `tgt_is_table`=0.
- R9: Mode 0 (`int_mode`=2'b00) gives `tgt_addr` = `periph_addr` as sampled at the grant boundary, with `tgt_is_table`=0.
- R10: Modes 1 and 3 (`int_mode`=2'b01 or 2'b11) give `tgt_addr`=`FIX_ADDR`, with `tgt_is_table`=0.
- R11: Mode 2 (`int_mode`=2'b10) gives `tgt_addr` = (`vec_base` + 2·`int_type`) mod 2^AW, with `tgt_is_table`=1. This is the address of the low byte; the high byte is at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | Bus-master request from the DMA controller |
| nmi_pin | input | 1 | Non-maskable interrupt line, edge sensitive |
| int_req | input | 1 | Maskable interrupt line, level sensitive |
| cycle_end | input | 1 | Strobe for the last clock of a machine cycle |
| instr_end | input | 1 | Strobe for the last clock of an instruction |
| ie_flag | input | 1 | Interrupt-enable flag of the core |
| ack | input | 1 | Core has taken the interrupt grant |
| int_mode | input | 2 | Handler-addressing mode for the maskable line |
| periph_addr | input | AW | Handler address supplied by the peripheral (mode 0) |
| int_type | input | TW | Type number supplied by the peripheral (mode 2) |
| vec_base | input | AW | Vector table base address (mode 2) |
| dma_grant | output | 1 | Bus granted to the DMA controller |
| irq_grant | output | 1 | Interrupt entry granted |
| irq_nmi | output | 1 | Granted interrupt is the non-maskable one |
| tgt_addr | output | AW | Handler address, or vector entry address |
| tgt_is_table | output | 1 | `tgt_addr` is a table entry to be read |

## Verification
The vectored mode is swept over all 128 type numbers at two table bases. One base is low and one sits near the top of the address space, so a wrong scale factor, a dropped bit or missing wrap-around shows up. The other modes are each tried with distinct peripheral addresses, which separates a captured address from a fixed one. Request combinations are presented at one boundary: DMA with NMI, NMI with INT, and INT with the flag clear and then set. These separate the ranking from the boundary rules. A one-cycle NMI pulse, a DMA hold during which instruction ends pass by, and an acknowledge followed by an empty boundary show whether the latch, the hold and the clearing each behave on their own.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DMA  = 2'd1,
    ST_IRQ  = 2'd2
  } arb_state_e;

  localparam logic [1:0] MODE_DIRECT = 2'b00;
  localparam logic [1:0] MODE_FIXED  = 2'b01;
  localparam logic [1:0] MODE_TABLE  = 2'b10;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise   = pin & ~prev_q;
  assign pend_d = rise | (pend_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R4: an edge is never lost
  a_r4_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pend_q);
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int AW = 16,
  parameter int TW = 7,
  parameter logic [AW-1:0] NMI_ADDR = '0,
  parameter logic [AW-1:0] FIX_ADDR = '0
) (
  input  logic          is_nmi,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] periph_addr,
  input  logic [TW-1:0] int_type,
  input  logic [AW-1:0] vec_base,
  output logic [AW-1:0] addr,
  output logic          is_table
);
  import irq_arb_pkg::*;
  localparam int PADW = AW - TW - 1;

  logic [AW-1:0] offs;

  generate
    if (PADW > 0) begin : g_pad
      assign offs = {{PADW{1'b0}}, int_type, 1'b0};
    end else begin : g_nopad
      assign offs = AW'({int_type, 1'b0});
    end
  endgenerate

  always_comb begin
    addr     = FIX_ADDR;
    is_table = 1'b0;
    if (is_nmi) begin
      addr = NMI_ADDR;
    end else begin
      case (mode)
        MODE_DIRECT: addr = periph_addr;
        MODE_TABLE: begin
          addr     = vec_base + offs;
          is_table = 1'b1;
        end
        default:     addr = FIX_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int AW = 16,
  parameter int TW = 7,
  parameter logic [AW-1:0] NMI_ADDR = 16'h0040,
  parameter logic [AW-1:0] FIX_ADDR = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic          nmi_pin,
  input  logic          int_req,
  input  logic          cycle_end,
  input  logic          instr_end,
  input  logic          ie_flag,
  input  logic          ack,
  input  logic [1:0]    int_mode,
  input  logic [AW-1:0] periph_addr,
  input  logic [TW-1:0] int_type,
  input  logic [AW-1:0] vec_base,
  output logic          dma_grant,
  output logic          irq_grant,
  output logic          irq_nmi,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_is_table
);
  import irq_arb_pkg::*;

  arb_state_e    st_q, st_d;
  logic          nmi_pend, nmi_clr, load;
  logic          src_q;
  logic [AW-1:0] addr_q, addr_c;
  logic          tbl_q, tbl_c;

  irq_edge_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (nmi_pin),
    .clr   (nmi_clr),
    .pend  (nmi_pend)
  );

  irq_vec_calc #(
    .AW(AW), .TW(TW), .NMI_ADDR(NMI_ADDR), .FIX_ADDR(FIX_ADDR)
  ) u_vec (
    .is_nmi      (nmi_pend),
    .mode        (int_mode),
    .periph_addr (periph_addr),
    .int_type    (int_type),
    .vec_base    (vec_base),
    .addr        (addr_c),
    .is_table    (tbl_c)
  );

  // next-state process
  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    nmi_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (dma_req && cycle_end) begin
          st_d = ST_DMA;
        end else if (instr_end && (nmi_pend || (int_req && ie_flag))) begin
          st_d = ST_IRQ;
          load = 1'b1;
        end
      end
      ST_DMA: if (!dma_req) st_d = ST_IDLE;
      ST_IRQ: begin
        if (ack) begin
          st_d    = ST_IDLE;
          nmi_clr = src_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= 1'b0;
      addr_q <= '0;
      tbl_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        src_q  <= nmi_pend;
        addr_q <= addr_c;
        tbl_q  <= tbl_c;
      end
    end
  end

  assign dma_grant    = (st_q == ST_DMA);
  assign irq_grant    = (st_q == ST_IRQ);
  assign irq_nmi      = src_q;
  assign tgt_addr     = addr_q;
  assign tgt_is_table = tbl_q;

  // R1
  a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_grant && irq_grant));
  // R2
  a_r2_dma_at_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_grant) |-> $past(dma_req && cycle_end));
  // R3
  a_r3_dma_held: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant && dma_req |=> dma_grant);
  // R4 / R5: interrupts start only at an instruction end
  a_r4_irq_at_instr_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_grant) |-> $past(instr_end));
  // R5
  a_r5_int_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_grant) && !irq_nmi |-> $past(ie_flag));
  // R7
  a_r7_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grant && !ack |=> irq_grant && $stable(tgt_addr) && $stable(irq_nmi));
  // R8
  a_r8_nmi_target: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grant && irq_nmi |-> tgt_addr == NMI_ADDR && !tgt_is_table);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam int AW = 16;
  localparam int TW = 7;
  localparam logic [15:0] NMI_A = 16'h0040;
  localparam logic [15:0] FIX_A = 16'h0100;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_req, nmi_pin, int_req, cycle_end, instr_end, ie_flag, ack;
  logic [1:0] int_mode;
  logic [AW-1:0] periph_addr, vec_base, tgt_addr;
  logic [TW-1:0] int_type;
  logic dma_grant, irq_grant, irq_nmi, tgt_is_table;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_arbiter #(.AW(AW), .TW(TW), .NMI_ADDR(NMI_A), .FIX_ADDR(FIX_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .nmi_pin(nmi_pin),
    .int_req(int_req), .cycle_end(cycle_end), .instr_end(instr_end),
    .ie_flag(ie_flag), .ack(ack), .int_mode(int_mode),
    .periph_addr(periph_addr), .int_type(int_type), .vec_base(vec_base),
    .dma_grant(dma_grant), .irq_grant(irq_grant), .irq_nmi(irq_nmi),
    .tgt_addr(tgt_addr), .tgt_is_table(tgt_is_table)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // pulse instr_end for one cycle; outputs sampled one negedge later
  task automatic boundary();
    instr_end = 1'b1; tick(); instr_end = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
    chk(irq_grant == 1'b0, "R7 grant drops after ack", irq_grant, 0);
  endtask

  task automatic int_case(input logic [1:0] m, input logic [15:0] pa,
                          input logic [6:0] ty, input logic [15:0] base,
                          input logic [15:0] exp_a, input bit exp_t, input string req);
    int_mode = m; periph_addr = pa; int_type = ty; vec_base = base;
    int_req = 1'b1; ie_flag = 1'b1;
    boundary();
    int_req = 1'b0; periph_addr = ~pa; int_type = ~ty;
    chk(irq_grant && !irq_nmi, req, {irq_grant, irq_nmi}, 2);
    chk(tgt_addr == exp_a && tgt_is_table == exp_t, req, tgt_addr, exp_a);
    do_ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dma_req = 0; nmi_pin = 0; int_req = 0; cycle_end = 0; instr_end = 0;
    ie_flag = 0; ack = 0; int_mode = 2'b00; periph_addr = '0; int_type = '0;
    vec_base = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!dma_grant && !irq_grant, "R1 reset grants low", {dma_grant, irq_grant}, 0);
    boundary();
    chk(!irq_grant, "R12/R4 no pending NMI after reset (R1)", irq_grant, 0);

    // R2: dma without cycle_end not granted; with it granted
    dma_req = 1; instr_end = 1; tick(); instr_end = 0;
    chk(!dma_grant, "R2 no grant without cycle_end", dma_grant, 0);
    cycle_end = 1; tick(); cycle_end = 0;
    chk(dma_grant && !irq_grant, "R2 dma granted at cycle end", dma_grant, 1);
    // R3: hold across boundaries with interrupts pending
    int_req = 1; ie_flag = 1; nmi_pin = 1;
    for (int i = 0; i < 6; i++) begin
      instr_end = i[0]; cycle_end = 1; tick();
      chk(dma_grant && !irq_grant, "R3 dma held R1", {dma_grant, irq_grant}, 2);
    end
    instr_end = 0; cycle_end = 0; nmi_pin = 0;
    dma_req = 0; instr_end = 1; tick(); instr_end = 0;
    chk(!dma_grant && !irq_grant, "R3 release, no grant at release boundary",
        {dma_grant, irq_grant}, 0);
    tick();
    chk(!irq_grant, "R3 no grant without boundary", irq_grant, 0);
    // R6: NMI (latched during DMA) beats INT
    boundary();
    chk(irq_grant && irq_nmi, "R6 NMI beats INT", irq_nmi, 1);
    chk(tgt_addr == NMI_A && !tgt_is_table, "R8 NMI target", tgt_addr, NMI_A);
    // R7 held until ack
    repeat (3) tick();
    chk(irq_grant && irq_nmi && tgt_addr == NMI_A, "R7 held", tgt_addr, NMI_A);
    do_ack();
    // after NMI cleared, INT granted at next boundary
    int_mode = 2'b01;
    boundary();
    chk(irq_grant && !irq_nmi && tgt_addr == FIX_A, "R3 INT after release R10",
        tgt_addr, FIX_A);
    int_req = 0;
    do_ack();
    boundary();
    chk(!irq_grant, "R7 NMI latch cleared by ack", irq_grant, 0);

    // R4: one-cycle NMI pulse, ie clear
    ie_flag = 0;
    nmi_pin = 1; tick(); nmi_pin = 0;
    repeat (3) tick();
    chk(!irq_grant, "R4 no grant without instr_end", irq_grant, 0);
    boundary();
    chk(irq_grant && irq_nmi, "R4 NMI ignores ie_flag", irq_nmi, 1);
    do_ack();

    // R5: INT with ie clear stays pending
    int_req = 1; ie_flag = 0;
    boundary(); boundary();
    chk(!irq_grant, "R5 masked while ie clear", irq_grant, 0);
    ie_flag = 1; int_mode = 2'b00; periph_addr = 16'h3A5C;
    boundary();
    chk(irq_grant && !irq_nmi && tgt_addr == 16'h3A5C, "R5 granted once ie set R9",
        tgt_addr, 16'h3A5C);
    int_req = 0;
    do_ack();

    // R2: DMA beats NMI and INT at the same edge
    nmi_pin = 1; tick(); nmi_pin = 0;
    int_req = 1; dma_req = 1; cycle_end = 1; instr_end = 1; tick();
    cycle_end = 0; instr_end = 0; dma_req = 0;
    chk(dma_grant && !irq_grant, "R2 DMA wins same cycle", dma_grant, 1);
    tick();
    int_req = 0;
    boundary();
    chk(irq_grant && irq_nmi, "R4 NMI kept through DMA", irq_nmi, 1);
    do_ack();

    // R9 mode 0 with several addresses
    int_case(2'b00, 16'h0000, 7'd5, 16'h0, 16'h0000, 1'b0, "R9 direct");
    int_case(2'b00, 16'hFFFF, 7'd5, 16'h0, 16'hFFFF, 1'b0, "R9 direct");
    int_case(2'b00, 16'h1234, 7'd5, 16'h0, 16'h1234, 1'b0, "R9 direct");
    // R10 modes 1 and 3
    int_case(2'b01, 16'h7777, 7'd9, 16'h0, FIX_A, 1'b0, "R10 fixed");
    int_case(2'b11, 16'h7777, 7'd9, 16'h0, FIX_A, 1'b0, "R10 reserved as fixed");
    // R11 full sweep of types at two bases
    for (int b = 0; b < 2; b++) begin
      logic [15:0] base;
      base = (b == 0) ? 16'h0200 : 16'hFFA0;
      for (int t = 0; t < 128; t++) begin
        int e;
        e = (int'(base) + 2 * t) & 16'hFFFF;
        int_case(2'b10, 16'h5555, 7'(t), base, 16'(e), 1'b1, "R11 vector entry");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule